// File: doc/BRIEF.md
# Load Memory-Access Hazard Gate

This block decides, each cycle, whether the load waiting in a load pipe may read memory. It looks at every store that is still live in the in-order retirement buffer. Only stores that are older than the load count, and age is measured by the circular distance from the buffer's head slot. If such a store has a known word address equal to the load's word address, the load is held back. An older store whose address has not been computed yet also holds the load, because the block cannot rule out an overlap.

A second output tells the address-generation stage whether every older store already has a known address. This keeps load address generation in program order with respect to earlier stores.

Stores change memory only when they retire at the buffer head, and at that point nothing older is outstanding. For that reason the block makes no check for write-after-write or write-after-read through memory. Store data forwarding and the cache are handled elsewhere.

The load side is a valid/ready stream:
- `ld_ready` is a pure function of the current buffer state and the load's tag and address. It does not depend on `ld_valid`.
- A load transfers in a cycle where both `ld_valid` and `ld_ready` are high.
- While `ld_valid` is high and `ld_ready` is low, the producer must hold `ld_tag` and `ld_addr` steady.
- Retiring or flushing a store clears its live bit on the following edge. The held load is therefore released in the cycle after that retirement or flush.

Top module: `ld_hazard_gate`

## Requirements
- R1: `ld_ready` is low while any live store that is older than the load has its address known and that address equals `ld_addr` in bits [31:2].
- R2: `ld_ready` is low while any live older store has its address-known bit clear, whatever the load address. Whenever `ld_ready` is high, `agen_ok` is also high.
- R3: `agen_ok` is high exactly when no live older store has its address-known bit clear. It does not depend on `ld_addr`.
- R4: A store in slot s is older than the load only when (s - head_ptr) mod 8 < (ld_tag - head_ptr) mod 8. Stores in younger slots, or in the load's own slot, never lower `ld_ready` or `agen_ok`, including when the slots wrap past index 7.
- R5: Slots whose live bit in `st_valid` is clear have no effect. With `st_valid` all zero, `ld_ready` and `agen_ok` are both high.
- R6: Address bits [1:0] take no part in the comparison. Addresses that differ only there match, and addresses that differ in bit 2 or above do not.
- R7: The outputs depend only on the current inputs. In the cycle after the blocking store's live bit is cleared, by retirement or by flush, `ld_ready` is high, provided no other older store blocks the load. With all inputs steady, the outputs stay steady.
- R8: A load whose tag equals `head_ptr` has no older store, so `ld_ready` and `agen_ok` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded property checks |
| rst_n | input | 1 | Active-low reset for the property checks |
| head_ptr | input | 3 | Slot index of the oldest entry in the retirement buffer |
| ld_valid | input | 1 | A load is presented for its memory access |
| ld_tag | input | 3 | Retirement-buffer slot held by the load |
| ld_addr | input | 32 | Effective byte address of the load |
| ld_ready | output | 1 | Load may perform its memory read this cycle |
| agen_ok | output | 1 | All older stores have known addresses |
| st_valid | input | 8 | Per slot: a live store occupies this slot |
| st_addr_known | input | 8 | Per slot: that store's address is computed |
| st_addr | input | 256 | Per slot s, bits [32*s+31:32*s] hold the store's byte address |

## Verification
The bench uses the default build: an 8-slot buffer, 3-bit tags, 32-bit addresses and a 2-bit word offset. Eight slots are enough to place the head near the top of the index range, so the older/younger split wraps through slot 0. They also allow the load to sit exactly at the head and a store to sit exactly at the head. Each slot gets its own distinct word address, so a match on one slot can never be mistaken for another. Directed steps then clear live bits one at a time and several at once, which reaches the release-after-retire and release-after-flush timing.

// File: rtl/ldg_pkg.sv
package ldg_pkg;

  // Per-slot verdict passed from the slot comparators to the top.
  typedef struct packed {
    logic blocks_load;   // this store forbids the memory read
    logic addr_pending;  // this store is older and its address is unknown
  } slot_verdict_t;

endpackage

// File: rtl/ldg_age_rank.sv
// Marks which buffer slots precede the load in program order,
// using circular distance from the head slot.
module ldg_age_rank #(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] head_ptr,
  input  logic [TAG_W-1:0] ld_tag,
  output logic [DEPTH-1:0] older
);

  logic [TAG_W-1:0] ld_dist;
  assign ld_dist = ld_tag - head_ptr;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    localparam logic [TAG_W-1:0] SLOT_IDX = TAG_W'(s);
    logic [TAG_W-1:0] slot_dist;
    assign slot_dist = SLOT_IDX - head_ptr;
    assign older[s]  = slot_dist < ld_dist;
  end

  // R4: the load's own slot never counts as older than the load.
  assert_own_slot_not_older_R4: assert property (
    @(posedge clk) disable iff (!rst_n) older[ld_tag] == 1'b0
  );

  // R8: nothing precedes the head entry.
  assert_head_has_no_elders_R8: assert property (
    @(posedge clk) disable iff (!rst_n) (ld_tag == head_ptr) |-> (older == '0)
  );

endmodule

// File: rtl/ldg_slot_cmp.sv
// One slot's verdict: compare a store's word address against the load.
module ldg_slot_cmp
  import ldg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_older,
  input  logic              st_live,
  input  logic              st_known,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [ADDR_W-1:0] ld_addr,
  output slot_verdict_t     verdict
);

  logic word_hit;
  logic relevant;

  assign word_hit = st_addr[ADDR_W-1:OFS_W] == ld_addr[ADDR_W-1:OFS_W];
  assign relevant = is_older & st_live;

  always_comb begin
    verdict.addr_pending = relevant & ~st_known;
    verdict.blocks_load  = relevant & (~st_known | word_hit);
  end

  // R4/R5: a younger or empty slot contributes nothing.
  assert_idle_slot_quiet_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
      (!is_older || !st_live) |-> (verdict == '0)
  );

  // R2: an unresolved address always blocks as well as pends.
  assert_pending_blocks_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
      verdict.addr_pending |-> verdict.blocks_load
  );

endmodule

// File: rtl/ldg_any.sv
// Wide OR of per-slot flags.
module ldg_any #(
  parameter int N = 8
) (
  input  logic [N-1:0] flags,
  output logic         any
);

  always_comb begin
    any = 1'b0;
    for (int i = 0; i < N; i++) any = any | flags[i];
  end

endmodule

// File: rtl/ld_hazard_gate.sv
// Decides whether a load may perform its memory read, given the live
// stores in the in-order retirement buffer.
module ld_hazard_gate
  import ldg_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 2,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int FLAT_W = DEPTH * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  head_ptr,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_ready,
  output logic              agen_ok,
  input  logic [DEPTH-1:0]  st_valid,
  input  logic [DEPTH-1:0]  st_addr_known,
  input  logic [FLAT_W-1:0] st_addr
);

  logic [DEPTH-1:0] older;
  logic [DEPTH-1:0] blk_vec;
  logic [DEPTH-1:0] pend_vec;
  logic             any_blk;
  logic             any_pend;

  ldg_age_rank #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .head_ptr (head_ptr),
    .ld_tag   (ld_tag),
    .older    (older)
  );

  for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
    slot_verdict_t v;
    ldg_slot_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .is_older (older[s]),
      .st_live  (st_valid[s]),
      .st_known (st_addr_known[s]),
      .st_addr  (st_addr[s*ADDR_W +: ADDR_W]),
      .ld_addr  (ld_addr),
      .verdict  (v)
    );
    assign blk_vec[s]  = v.blocks_load;
    assign pend_vec[s] = v.addr_pending;
  end

  ldg_any #(.N(DEPTH)) u_any_blk  (.flags(blk_vec),  .any(any_blk));
  ldg_any #(.N(DEPTH)) u_any_pend (.flags(pend_vec), .any(any_pend));

  assign ld_ready = ~any_blk;
  assign agen_ok  = ~any_pend;

  // Slot at the head, when the load is not the head itself.
  logic head_match;
  assign head_match = st_valid[head_ptr] && st_addr_known[head_ptr] &&
                      (ld_tag != head_ptr) &&
                      (st_addr[head_ptr*ADDR_W +: ADDR_W] >> OFS_W) ==
                      (ld_addr >> OFS_W);

  assert_head_store_blocks_R1: assert property (
    @(posedge clk) disable iff (!rst_n) head_match |-> !ld_ready
  );

  assert_go_needs_addresses_R2: assert property (
    @(posedge clk) disable iff (!rst_n) ld_ready |-> agen_ok
  );

  assert_empty_buffer_go_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
      (st_valid == '0) |-> (ld_ready && agen_ok)
  );

  assert_load_at_head_go_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
      (ld_tag == head_ptr) |-> (ld_ready && agen_ok)
  );

  assert_steady_inputs_steady_out_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
      ($stable(head_ptr) && $stable(ld_tag) && $stable(ld_addr) &&
       $stable(st_valid) && $stable(st_addr_known) && $stable(st_addr))
      |-> ($stable(ld_ready) && $stable(agen_ok))
  );

  // Valid-qualified transfer is the consumer's concern; keep it observed.
  logic unused_valid;
  assign unused_valid = ld_valid;

endmodule

// File: tb/ld_hazard_gate_bench.sv
`timescale 1ns/1ps
module ld_hazard_gate_bench;

  localparam int DEPTH = 8;
  localparam int AW    = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        head_ptr = '0;
  logic              ld_valid = 1'b0;
  logic [2:0]        ld_tag = '0;
  logic [AW-1:0]     ld_addr = '0;
  logic              ld_ready;
  logic              agen_ok;
  logic [DEPTH-1:0]  st_valid = '0;
  logic [DEPTH-1:0]  st_addr_known = '0;
  logic [DEPTH*AW-1:0] st_addr = '0;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ld_hazard_gate u_ld_hazard_gate (
    .clk(clk), .rst_n(rst_n), .head_ptr(head_ptr), .ld_valid(ld_valid),
    .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_ready(ld_ready),
    .agen_ok(agen_ok), .st_valid(st_valid), .st_addr_known(st_addr_known),
    .st_addr(st_addr)
  );

  function automatic logic [AW-1:0] slot_a(int s);
    return 32'h1000_0000 | (AW'(s) << 4);
  endfunction

  // {head[55:53], tag[52:50], valid[49:42], known[41:34], addr[33:2], ready[1], agen[0]}
  localparam logic [55:0] TBL [0:12] = '{
    {3'd0, 3'd3, 8'h00, 8'h00, 32'h1000_0010, 1'b1, 1'b1}, // R5 empty
    {3'd0, 3'd3, 8'h02, 8'h02, 32'h1000_0010, 1'b0, 1'b1}, // R1 hit slot1
    {3'd0, 3'd3, 8'h02, 8'h02, 32'h1000_0020, 1'b1, 1'b1}, // R1 miss
    {3'd0, 3'd3, 8'h04, 8'h00, 32'h1000_0070, 1'b0, 1'b0}, // R2 R3 unknown
    {3'd0, 3'd3, 8'h20, 8'h00, 32'h1000_0050, 1'b1, 1'b1}, // R4 younger
    {3'd6, 3'd1, 8'h80, 8'h80, 32'h1000_0070, 1'b0, 1'b1}, // R4 wrap older
    {3'd6, 3'd1, 8'h08, 8'h08, 32'h1000_0030, 1'b1, 1'b1}, // R4 wrap younger
    {3'd6, 3'd1, 8'h01, 8'h00, 32'h1000_0000, 1'b0, 1'b0}, // R3 wrap unknown
    {3'd5, 3'd5, 8'hFF, 8'h00, 32'h1000_0050, 1'b1, 1'b1}, // R8 load at head
    {3'd0, 3'd4, 8'h04, 8'h04, 32'h1000_0023, 1'b0, 1'b1}, // R6 offset match
    {3'd0, 3'd4, 8'h04, 8'h04, 32'h1000_0024, 1'b1, 1'b1}, // R6 word differs
    {3'd2, 3'd7, 8'h0C, 8'h0C, 32'h1000_0060, 1'b1, 1'b1}, // R1 no hit
    {3'd2, 3'd7, 8'h44, 8'h04, 32'h1000_0090, 1'b0, 1'b0}  // R3 slot6 unknown
  };

  task automatic check(string req, logic got_r, logic got_a,
                       logic exp_r, logic exp_a);
    n_vec++;
    if (got_r !== exp_r || got_a !== exp_a) begin
      n_bad++;
      $display("FAIL %s: ready/agen actual %b/%b expected %b/%b",
               req, got_r, got_a, exp_r, exp_a);
    end
  endtask

  task automatic drive(logic [2:0] h, logic [2:0] t, logic [7:0] v,
                       logic [7:0] k, logic [AW-1:0] a);
    @(posedge clk); #1;
    head_ptr = h; ld_tag = t; st_valid = v; st_addr_known = k;
    ld_addr = a; ld_valid = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 5000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < DEPTH; s++) st_addr[s*AW +: AW] = slot_a(s);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset", ld_ready, agen_ok, 1'b1, 1'b1);

    for (int i = 0; i < 13; i++) begin
      drive(TBL[i][55:53], TBL[i][52:50], TBL[i][49:42], TBL[i][41:34],
            TBL[i][33:2]);
      check($sformatf("table[%0d]", i), ld_ready, agen_ok,
            TBL[i][1], TBL[i][0]);
    end

    // R7: retire of the blocking store at the head releases the load.
    drive(3'd1, 3'd4, 8'h02, 8'h02, slot_a(1));
    check("R7 blocked", ld_ready, agen_ok, 1'b0, 1'b1);
    drive(3'd2, 3'd4, 8'h00, 8'h00, slot_a(1));
    check("R7 after retire", ld_ready, agen_ok, 1'b1, 1'b1);

    // R7: flush clears two blockers at once.
    drive(3'd0, 3'd5, 8'h0A, 8'h08, slot_a(3));
    check("R7 two blockers", ld_ready, agen_ok, 1'b0, 1'b0);
    drive(3'd0, 3'd5, 8'h00, 8'h00, slot_a(3));
    check("R7 after flush", ld_ready, agen_ok, 1'b1, 1'b1);

    // R1: store at head, load elsewhere, same word.
    drive(3'd3, 3'd6, 8'h08, 8'h08, slot_a(3) + 32'd1);
    check("R1 head store", ld_ready, agen_ok, 1'b0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule